// File: doc/BRIEF.md
# Parallel FIFO Peripheral Port

This block is the device end of an 8-bit asynchronous byte port that an external controller drives with strobes. The controller reads bytes that internal logic has queued, and writes bytes that internal logic then drains. Two active-low status flags tell the controller when a byte can be read and when a byte can be written. The block drives the shared data lines only while the read strobe is held low.

Both strobes are asynchronous to the block. Each passes through a flop synchroniser, and its edges are detected in the single system clock domain. The byte under a write strobe travels through a delay line of matching depth, so the value that is stored is the one present at the last sample before the strobe fell. After every accepted access, the matching flag is held inactive for a programmable number of system clocks. The controller therefore sees the flag drop out before it issues the next access. An access attempted while its flag is inactive has no effect and sets a sticky error bit.

Internal logic feeds the receive queue through a valid/ready stream and takes from the transmit queue through a second stream. Each queue is a parameterised synchronous FIFO.

Top module: `pfifo_port`

## Requirements
- R1: Reset gives rx_avail_no=1, tx_space_no=0, data_oe_o=0, err_o=0, tx_valid_o=0 and rx_ready_o=1.
- R2: rx_avail_no is 0 only while the receive queue holds at least one byte and no read hold-off is running.
- R3: data_oe_o is 1 exactly while rd_strobe_ni is 0. During an accepted read, data_o shows the oldest queued byte. That byte is removed only once the release (0 to 1) of rd_strobe_ni has passed through the synchroniser.
- R4: On the cycle after an accepted read removes its byte, rx_avail_no goes to 1 and stays there for HOLD_CYC clocks.
- R5: tx_space_no is 0 only while the transmit queue has room and no write hold-off is running. With DEPTH bytes held, it stays 1.
- R6: A falling edge (1 to 0) of wr_strobe_i stores the data_i value from the last synchronised sample where wr_strobe_i was still 1. Changes of data_i after the fall do not affect the stored byte.
- R7: On the cycle after an accepted write stores its byte, tx_space_no goes to 1 and stays there for HOLD_CYC clocks.
- R8: A read strobe that falls while rx_avail_no=1 removes no byte. A write strobe that falls while tx_space_no=1 stores no byte. Either one sets err_o.
- R9: Once set, err_o stays 1 until rst_ni is asserted.
- R10: rx_ready_o is 0 when the receive queue holds DEPTH bytes. tx_valid_o is 1 whenever the transmit queue is not empty. Both queues keep bytes in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_strobe_ni | input | 1 | Read strobe from controller, active low, asynchronous |
| wr_strobe_i | input | 1 | Write strobe from controller; the byte is taken on its falling edge |
| data_i | input | DATA_W | Data lines as seen by the block |
| data_o | output | DATA_W | Byte driven towards the data lines |
| data_oe_o | output | 1 | Output enable for data_o on the shared lines |
| rx_avail_no | output | 1 | Byte available to read, active low |
| tx_space_no | output | 1 | Room to write, active low |
| err_o | output | 1 | Sticky access error |
| rx_valid_i | input | 1 | Receive stream valid from internal logic |
| rx_ready_o | output | 1 | Receive stream ready |
| rx_data_i | input | DATA_W | Receive stream byte |
| tx_valid_o | output | 1 | Transmit stream valid to internal logic |
| tx_ready_i | input | 1 | Transmit stream ready |
| tx_data_o | output | DATA_W | Transmit stream byte |

## Verification
The bench times the hold-off after each read and each write, clock by clock. A design that started the count late or stopped it early would let the flag return too soon or too late. It changes data_i one clock after the write strobe falls. A design that sampled the bus after the synchroniser instead of through the matched delay would store the wrong byte. It also makes a second read during the hold-off and one extra write into a full queue. A design that did not ignore these would lose a receive byte or add a transmit byte, and the scoreboard would catch the mismatch. It confirms that the error bit set by these accesses survives until reset.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_t;
endpackage

// File: rtl/pfp_sync.sv
module pfp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             async_i,
  output pfp_pkg::strobe_t st_o
);
  localparam int unsigned LEN = STAGES + 1;

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [LEN-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= {LEN{RST_VAL}};
    else         chain <= {chain[LEN-2:0], async_i};
  end

  assign st_o.fall = chain[STAGES] & ~chain[STAGES-1];
  assign st_o.rise = ~chain[STAGES] & chain[STAGES-1];
endmodule

// File: rtl/pfp_delay.sv
module pfp_delay #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // one stage deeper than the strobe synchroniser: aligns with its "previous" tap
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < int'(LEN); i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[LEN-1];
endmodule

// File: rtl/pfp_holdoff.sv
module pfp_holdoff #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  generate
    if (HOLD_CYC == 0) begin : g_none
      assign busy_o = 1'b0;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(HOLD_CYC + 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt <= '0;
        else if (start_i)       cnt <= CW'(HOLD_CYC);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end

      assign busy_o = (cnt != '0);

      p_busy_after_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
      p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= CW'(HOLD_CYC));
    end
  endgenerate
endmodule

// File: rtl/pfp_fifo.sv
module pfp_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign data_o = mem[rd_ptr];

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  p_full_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  p_empty_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/pfifo_port.sv
module pfifo_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned HOLD_CYC    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_strobe_ni,
  input  logic              wr_strobe_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rx_avail_no,
  output logic              tx_space_no,
  output logic              err_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o
);
  import pfp_pkg::*;

  strobe_t           rd_st, wr_st;
  logic [DATA_W-1:0] wr_byte;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic              rx_busy, tx_busy;
  logic              rd_open;
  logic              rx_pop, tx_push;

  pfp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(rd_strobe_ni), .st_o(rd_st));

  pfp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(wr_strobe_i), .st_o(wr_st));

  pfp_delay #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_wr_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(wr_byte));

  pfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(rx_valid_i), .data_i(rx_data_i),
    .pop_i(rx_pop), .data_o(data_o),
    .full_o(rx_full), .empty_o(rx_empty));

  pfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(tx_push), .data_i(wr_byte),
    .pop_i(tx_valid_o & tx_ready_i), .data_o(tx_data_o),
    .full_o(tx_full), .empty_o(tx_empty));

  pfp_holdoff #(.HOLD_CYC(HOLD_CYC)) u_rx_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rx_pop), .busy_o(rx_busy));

  pfp_holdoff #(.HOLD_CYC(HOLD_CYC)) u_tx_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_push), .busy_o(tx_busy));

  assign rx_avail_no = rx_empty | rx_busy;
  assign tx_space_no = tx_full | tx_busy;
  assign rx_ready_o  = ~rx_full;
  assign tx_valid_o  = ~tx_empty;
  assign data_oe_o   = ~rd_strobe_ni;

  assign rx_pop  = rd_st.rise & rd_open;
  assign tx_push = wr_st.fall & ~tx_space_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_open <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (rd_st.fall && !rx_avail_no) rd_open <= 1'b1;
      else if (rd_st.rise)            rd_open <= 1'b0;
      if ((rd_st.fall && rx_avail_no) || (wr_st.fall && tx_space_no)) err_o <= 1'b1;
    end
  end

  p_pop_nonempty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop |-> !rx_empty);
  p_data_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_open && !rd_st.rise) |=> $stable(data_o));
  p_rx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop |=> rx_avail_no);
  p_push_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push |-> !tx_full);
  p_no_push_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st.rise |-> !tx_push);
  p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push |=> tx_space_no);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/tb_pfifo_port.sv
module tb_pfifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int HOLD  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr = 1'b0;
  logic [DW-1:0] din = '0, rx_data = '0;
  logic rx_valid = 1'b0, tx_rdy = 1'b1;
  logic [DW-1:0] dout, tx_data;
  logic oe, rx_avail_n, tx_space_n, err, rx_ready, tx_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_rx[$];
  logic [DW-1:0] exp_tx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfifo_port #(.DATA_W(DW), .DEPTH(DEPTH), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_strobe_ni(rd_n), .wr_strobe_i(wr),
    .data_i(din), .data_o(dout), .data_oe_o(oe),
    .rx_avail_no(rx_avail_n), .tx_space_no(tx_space_n), .err_o(err),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_rdy), .tx_data_o(tx_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: transmit stream scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_rdy) begin
      if (exp_tx.size() == 0) chk(1'b0, "R8 unexpected tx byte", int'(tx_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_tx.pop_front();
        chk(tx_data == e, "R6 tx byte", int'(tx_data), int'(e));
      end
    end
  end

  task automatic rx_push(input logic [DW-1:0] b);
    bit ok;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 ok = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
    if (ok) exp_rx.push_back(b);
  endtask

  task automatic port_read();
    logic [DW-1:0] e;
    int cnt;
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(oe == 1'b1, "R3 oe during read", int'(oe), 1);
    e = exp_rx.pop_front();
    chk(dout == e, "R3 read byte", int'(dout), int'(e));
    rd_n = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0, "R3 bus released", int'(oe), 0);
    repeat (2) @(negedge clk);
    if (exp_rx.size() > 0) begin
      cnt = 0;
      while (rx_avail_n && cnt < 100) begin cnt++; @(negedge clk); end
      chk(cnt == HOLD, "R4 read hold-off length", cnt, HOLD);
    end else repeat (HOLD + 2) @(negedge clk);
  endtask

  task automatic port_write(input logic [DW-1:0] b, input bit accept, input bit meas);
    int cnt;
    @(negedge clk); din = b; wr = 1'b1;
    repeat (3) @(negedge clk);
    wr = 1'b0;
    if (accept) exp_tx.push_back(b);
    @(negedge clk); din = ~b;   // changed right after the fall
    repeat (2) @(negedge clk);
    if (meas) begin
      cnt = 0;
      while (tx_space_n && cnt < 100) begin cnt++; @(negedge clk); end
      chk(cnt == HOLD, "R7 write hold-off length", cnt, HOLD);
    end else repeat (HOLD + 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_avail_n == 1'b1, "R1 rx_avail_no", int'(rx_avail_n), 1);
    chk(tx_space_n == 1'b0, "R1 tx_space_no", int'(tx_space_n), 0);
    chk(oe == 1'b0, "R1 data_oe_o", int'(oe), 0);
    chk(err == 1'b0, "R1 err_o", int'(err), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid_o", int'(tx_valid), 0);
    chk(rx_ready == 1'b1, "R1 rx_ready_o", int'(rx_ready), 1);
    rst_n = 1'b1;

    // R2, R3, R4: basic reads
    rx_push(8'hA5); rx_push(8'h3C); rx_push(8'h7E);
    repeat (2) @(negedge clk);
    chk(rx_avail_n == 1'b0, "R2 flag low with data", int'(rx_avail_n), 0);
    port_read(); port_read(); port_read();
    chk(rx_avail_n == 1'b1, "R2 flag high when empty", int'(rx_avail_n), 1);

    // R8: read during hold-off is ignored
    rx_push(8'h11); rx_push(8'h22);
    repeat (2) @(negedge clk);
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    begin
      logic [DW-1:0] e;
      e = exp_rx.pop_front();
      chk(dout == e, "R3 read byte", int'(dout), int'(e));
    end
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_avail_n == 1'b1, "R4 flag high in hold-off", int'(rx_avail_n), 1);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R8 err after read in hold-off", int'(err), 1);
    rd_n = 1'b1;
    repeat (HOLD + 4) @(negedge clk);
    port_read();   // must still return 8'h22
    chk(err == 1'b1, "R9 err sticky", int'(err), 1);

    // R9: reset clears error
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0, "R9 err cleared by reset", int'(err), 0);

    // R6, R7: writes drained by the stream
    port_write(8'h5A, 1'b1, 1'b1);
    port_write(8'hC3, 1'b1, 1'b1);
    port_write(8'h00, 1'b1, 1'b1);
    port_write(8'hFF, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk(exp_tx.size() == 0, "R10 all tx bytes delivered", exp_tx.size(), 0);

    // R5, R8: fill transmit queue, then one extra write
    tx_rdy = 1'b0;
    for (int i = 0; i < DEPTH; i++) port_write(8'(8'h40 + i), 1'b1, 1'b0);
    chk(tx_space_n == 1'b1, "R5 flag high when full", int'(tx_space_n), 1);
    chk(tx_valid == 1'b1, "R10 tx_valid_o with data", int'(tx_valid), 1);
    chk(err == 1'b0, "R8 no err before overflow", int'(err), 0);
    port_write(8'hEE, 1'b0, 1'b0);
    chk(err == 1'b1, "R8 err after write while full", int'(err), 1);
    @(negedge clk); tx_rdy = 1'b1;
    repeat (DEPTH + 10) @(negedge clk);
    chk(exp_tx.size() == 0, "R8 extra write not stored", exp_tx.size(), 0);
    chk(tx_space_n == 1'b0, "R5 flag low after drain", int'(tx_space_n), 0);

    // R10: receive queue full
    for (int i = 0; i < DEPTH; i++) rx_push(8'(8'h80 + 3*i));
    @(negedge clk);
    #1 chk(rx_ready == 1'b0, "R10 rx_ready_o low when full", int'(rx_ready), 0);
    rx_push(8'h99);
    chk(exp_rx.size() == DEPTH, "R10 no push when full", exp_rx.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) port_read();
    chk(rx_avail_n == 1'b1, "R2 empty after draining", int'(rx_avail_n), 1);

    finish_run();
  end
endmodule